// File: doc/BRIEF.md
# Fully Associative Cache Controller

This block is a small cache placed between a processor-side request stream and a main-memory port. Any memory block can be held in any slot. Each request's tag is compared against every slot at once. By default the cache has four slots, each holding one 32-bit block, and uses a 6-bit byte address. The address splits into a 2-bit byte offset and a 4-bit tag. There is no index field, and the block size is always a power of two bytes. A miss fetches the whole block in one memory access. The block goes into the lowest-numbered empty slot if there is one. Otherwise it replaces the least recently used slot, and a modified victim is written to memory before the refill read.

Two build-time switches set the write policy:
- `WRITE_BACK` chooses how a write hit is handled. When set, the write stays in the cache and the slot is marked dirty. When clear, the write goes through to memory as well.
- `WRITE_ALLOC` chooses how a write miss is handled. When set, the block is fetched and then written. When clear, only memory is written.

Two saturating counters report how many lookups hit and how many missed.

All data-carrying channels use a valid/ready handshake:
- A processor request transfers on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Ready stays low until the response has been taken.
- A response is held, with its data unchanged, for as long as `cpu_rsp_ready` is low.
- A memory request is held unchanged until `mem_req_ready` is high.
- Memory read data is accepted on any cycle where `mem_rsp_valid` is high. The cache never stalls memory read data.

Top module: `fac_cache`

## Requirements
- R1: After reset every slot is empty, both counters read 0, `cpu_req_ready` is 1 and `mem_req_valid` is 0, so the first access to any block misses.
- R2: A request hits exactly when a valid slot holds a tag equal to address bits [ADDR_W-1:OFF_W]. The offset bits do not affect the lookup. A read hit returns the slot's block and makes no memory access.
- R3: A read miss issues one memory read at the block address with the offset bits set to 0. The block is placed in the lowest-numbered empty slot when one exists, and the response carries the fetched block.
- R4: When every slot is valid, a miss replaces the least recently used slot. Every hit and every fill makes the touched slot the most recently used.
- R5: With `WRITE_BACK`=0, a write hit updates the slot and issues exactly one memory write of the new block at the block address. No slot is ever marked dirty.
- R6: With `WRITE_BACK`=1, a write hit updates only the slot and marks it dirty. Evicting a dirty slot issues one memory write of the old block at its own address before the refill read. Evicting a clean slot writes nothing.
- R7: With `WRITE_ALLOC`=1, a write miss first fetches the block like a read miss and then completes as a write hit.
- R8: With `WRITE_ALLOC`=0, a write miss issues exactly one memory write and leaves every slot unchanged.
- R9: Each accepted request adds exactly one to either `hit_count` or `miss_count`. Each counter stops at 2^CNT_W-1.
- R10: `cpu_req_ready` is low from the accepting cycle until the response is taken. While `cpu_rsp_valid` is high and `cpu_rsp_ready` is low, the response and its data do not change.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request's write flag, address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 8*2^OFF_W | Write data (one block) |
| cpu_rsp_valid | output | 1 | Response present |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | 8*2^OFF_W | Read data; for writes, the written block |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = block write, 0 = block read |
| mem_req_addr | output | ADDR_W | Block address, offset bits 0 |
| mem_req_wdata | output | 8*2^OFF_W | Block written to memory |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 8*2^OFF_W | Returned block |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
Two copies run side by side on the same stimulus, one write-back/write-allocate and one write-through/no-write-allocate. This separates the write-hit and write-miss policies through the memory write and read traffic each access causes.

The stimulus patterns have distinct purposes:
- A short read sequence with repeated and reordered blocks pins down the hit/miss pattern that true LRU produces.
- A long pseudo-random read/write mix over all 64 addresses stresses eviction of dirty and clean victims against a reference model.
- A sweep of every byte address shows that offsets do not split blocks.
- A long run of hits drives both counters to saturation.

Memory back-pressure and delayed response acceptance run throughout, and at the end the memory image is compared with the expected contents.

// File: rtl/fac_pkg.sv
package fac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_MEM_WR,
    ST_RESP
  } fac_state_e;

endpackage

// File: rtl/fac_tag_match.sv
module fac_tag_match #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]            slot_valid,
  input  logic [SLOTS-1:0][TAG_W-1:0] slot_tag,
  input  logic [TAG_W-1:0]            probe_tag,
  output logic [SLOTS-1:0]            hit_vec,
  output logic                        hit,
  output logic [SLOT_W-1:0]           hit_idx,
  output logic                        have_free,
  output logic [SLOT_W-1:0]           free_idx
);

  // every slot compared in parallel
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit_vec[g] = slot_valid[g] && (slot_tag[g] == probe_tag);
  end

  assign hit       = |hit_vec;
  assign have_free = ~&slot_valid;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i])     hit_idx  = SLOT_W'(i);
      if (!slot_valid[i]) free_idx = SLOT_W'(i);
    end
  end

endmodule

// File: rtl/fac_lru.sv
module fac_lru #(
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [SLOT_W-1:0] touch_idx,
  output logic [SLOT_W-1:0] victim_idx
);

  localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] age_q [SLOTS];
  logic [SLOTS-1:0]  oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) age_q[i] <= SLOT_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (SLOT_W'(i) == touch_idx)            age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (oldest_vec[i]) victim_idx = SLOT_W'(i);
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R4
  AST_LRU_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0); // R4

endmodule

// File: rtl/fac_sat_counter.sv
module fac_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (inc && ~&count)   count <= count + 1'b1;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) |=> (&count)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R9

endmodule

// File: rtl/fac_cache.sv
module fac_cache
  import fac_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int OFF_W       = 2,
  parameter int SLOTS       = 4,
  parameter int CNT_W       = 8,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1,
  localparam int BLK_W      = 8 * (2 ** OFF_W),
  localparam int TAG_W      = ADDR_W - OFF_W,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [BLK_W-1:0]  cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [BLK_W-1:0]  cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BLK_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BLK_W-1:0]  mem_rsp_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  fac_state_e st_q;

  logic [SLOTS-1:0]            valid_q;
  logic [SLOTS-1:0]            dirty_q;
  logic [SLOTS-1:0][TAG_W-1:0] tag_q;
  logic [SLOTS-1:0][BLK_W-1:0] data_q;

  logic              req_write_q;
  logic [TAG_W-1:0]  req_tag_q;
  logic [BLK_W-1:0]  req_wdata_q;
  logic [SLOT_W-1:0] sel_q;
  logic [BLK_W-1:0]  rsp_q;

  logic [SLOTS-1:0]  hit_vec;
  logic              hit;
  logic [SLOT_W-1:0] hit_idx;
  logic              have_free;
  logic [SLOT_W-1:0] free_idx;
  logic [SLOT_W-1:0] lru_victim;
  logic [SLOT_W-1:0] victim_idx;
  logic              touch_en;
  logic [SLOT_W-1:0] touch_idx;
  logic              hit_inc;
  logic              miss_inc;
  logic              unused_offset_bits;

  assign unused_offset_bits = ^cpu_req_addr[OFF_W-1:0];

  fac_tag_match #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_match (
    .slot_valid (valid_q),
    .slot_tag   (tag_q),
    .probe_tag  (req_tag_q),
    .hit_vec    (hit_vec),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .have_free  (have_free),
    .free_idx   (free_idx)
  );

  assign touch_en  = (st_q == ST_LOOKUP && hit) || (st_q == ST_FILL_WAIT && mem_rsp_valid);
  assign touch_idx = (st_q == ST_LOOKUP) ? hit_idx : sel_q;

  fac_lru #(.SLOTS(SLOTS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (lru_victim)
  );

  assign victim_idx = have_free ? free_idx : lru_victim;
  assign hit_inc    = (st_q == ST_LOOKUP) && hit;
  assign miss_inc   = (st_q == ST_LOOKUP) && !hit;

  fac_sat_counter #(.W(CNT_W)) u_hits (
    .clk (clk), .rst_n (rst_n), .inc (hit_inc), .count (hit_count)
  );
  fac_sat_counter #(.W(CNT_W)) u_misses (
    .clk (clk), .rst_n (rst_n), .inc (miss_inc), .count (miss_count)
  );

  // processor side
  assign cpu_req_ready = (st_q == ST_IDLE);
  assign cpu_rsp_valid = (st_q == ST_RESP);
  assign cpu_rsp_rdata = rsp_q;

  // memory side, driven from held state so it is stable under back-pressure
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = {req_tag_q, {OFF_W{1'b0}}};
    mem_req_wdata = req_wdata_q;
    unique case (st_q)
      ST_EVICT: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {tag_q[sel_q], {OFF_W{1'b0}}};
        mem_req_wdata = data_q[sel_q];
      end
      ST_FILL_REQ: mem_req_valid = 1'b1;
      ST_MEM_WR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      valid_q     <= '0;
      dirty_q     <= '0;
      tag_q       <= '0;
      data_q      <= '0;
      req_write_q <= 1'b0;
      req_tag_q   <= '0;
      req_wdata_q <= '0;
      sel_q       <= '0;
      rsp_q       <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cpu_req_valid) begin
          req_write_q <= cpu_req_write;
          req_tag_q   <= cpu_req_addr[ADDR_W-1:OFF_W];
          req_wdata_q <= cpu_req_wdata;
          st_q        <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            sel_q <= hit_idx;
            if (!req_write_q) begin
              rsp_q <= data_q[hit_idx];
              st_q  <= ST_RESP;
            end else begin
              data_q[hit_idx] <= req_wdata_q;
              rsp_q           <= req_wdata_q;
              if (WRITE_BACK) begin
                dirty_q[hit_idx] <= 1'b1;
                st_q             <= ST_RESP;
              end else begin
                st_q <= ST_MEM_WR;
              end
            end
          end else if (req_write_q && !WRITE_ALLOC) begin
            rsp_q <= req_wdata_q;
            st_q  <= ST_MEM_WR;
          end else begin
            sel_q <= victim_idx;
            st_q  <= (valid_q[victim_idx] && dirty_q[victim_idx]) ? ST_EVICT : ST_FILL_REQ;
          end
        end
        ST_EVICT:    if (mem_req_ready) st_q <= ST_FILL_REQ;
        ST_FILL_REQ: if (mem_req_ready) st_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          valid_q[sel_q] <= 1'b1;
          tag_q[sel_q]   <= req_tag_q;
          if (!req_write_q) begin
            data_q[sel_q]  <= mem_rsp_rdata;
            dirty_q[sel_q] <= 1'b0;
            rsp_q          <= mem_rsp_rdata;
            st_q           <= ST_RESP;
          end else begin
            data_q[sel_q]  <= req_wdata_q;
            dirty_q[sel_q] <= WRITE_BACK;
            rsp_q          <= req_wdata_q;
            st_q           <= WRITE_BACK ? ST_RESP : ST_MEM_WR;
          end
        end
        ST_MEM_WR: if (mem_req_ready) st_q <= ST_RESP;
        ST_RESP:   if (cpu_rsp_ready) st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_EVICT_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVICT) |-> (valid_q[sel_q] && dirty_q[sel_q])); // R6
  AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write && st_q == ST_EVICT)
      |=> (mem_req_valid && !mem_req_write)); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata))); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready); // R10

  if (!WRITE_BACK) begin : g_wt_chk
    AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q == '0); // R5
  end

endmodule

// File: tb/fac_cache_test.sv
module fac_cache_test;

  localparam int ADDR_W = 6;
  localparam int NBLK   = 16;
  localparam int NSLOT  = 4;
  localparam int CMAX   = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  c_valid, c_write, r_ready, m_ready, m_rvalid;
  logic [5:0]  c_addr [2];
  logic [31:0] c_wdata [2];
  logic [31:0] m_rdata [2];
  wire  [1:0]  c_ready, r_valid, m_valid, m_write;
  wire  [31:0] r_data [2];
  wire  [5:0]  m_addr [2];
  wire  [31:0] m_wdata [2];
  wire  [7:0]  hcnt [2];
  wire  [7:0]  mcnt [2];

  fac_cache #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(c_valid[0]), .cpu_req_ready(c_ready[0]), .cpu_req_write(c_write[0]),
    .cpu_req_addr(c_addr[0]), .cpu_req_wdata(c_wdata[0]),
    .cpu_rsp_valid(r_valid[0]), .cpu_rsp_ready(r_ready[0]), .cpu_rsp_rdata(r_data[0]),
    .mem_req_valid(m_valid[0]), .mem_req_ready(m_ready[0]), .mem_req_write(m_write[0]),
    .mem_req_addr(m_addr[0]), .mem_req_wdata(m_wdata[0]),
    .mem_rsp_valid(m_rvalid[0]), .mem_rsp_rdata(m_rdata[0]),
    .hit_count(hcnt[0]), .miss_count(mcnt[0])
  );

  fac_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) uut_wt (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(c_valid[1]), .cpu_req_ready(c_ready[1]), .cpu_req_write(c_write[1]),
    .cpu_req_addr(c_addr[1]), .cpu_req_wdata(c_wdata[1]),
    .cpu_rsp_valid(r_valid[1]), .cpu_rsp_ready(r_ready[1]), .cpu_rsp_rdata(r_data[1]),
    .mem_req_valid(m_valid[1]), .mem_req_ready(m_ready[1]), .mem_req_write(m_write[1]),
    .mem_req_addr(m_addr[1]), .mem_req_wdata(m_wdata[1]),
    .mem_rsp_valid(m_rvalid[1]), .mem_rsp_rdata(m_rdata[1]),
    .hit_count(hcnt[1]), .miss_count(mcnt[1])
  );

  // memory models
  logic [31:0] mem [2][NBLK];
  int wr_cnt [2];
  int rd_cnt [2];
  int cyc = 0;

  function automatic logic [31:0] init_word(int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0111);
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      m_rvalid[k] <= 1'b0;
      if (!rst_n) begin
        for (int i = 0; i < NBLK; i++) mem[k][i] <= init_word(i);
        wr_cnt[k] <= 0;
        rd_cnt[k] <= 0;
      end else if (m_valid[k] && m_ready[k]) begin
        if (m_write[k]) begin
          mem[k][m_addr[k][5:2]] <= m_wdata[k];
          wr_cnt[k] <= wr_cnt[k] + 1;
        end else begin
          m_rvalid[k] <= 1'b1;
          m_rdata[k]  <= mem[k][m_addr[k][5:2]];
          rd_cnt[k]   <= rd_cnt[k] + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int k = 0; k < 2; k++) m_ready[k] <= ((cyc + k) % 3) != 1;
  end

  // bookkeeping and reference model
  int checks = 0;
  int errors = 0;
  logic [31:0] gm [NBLK];
  bit rv [2][NSLOT];
  bit rd [2][NSLOT];
  int rtag [2][NSLOT];
  int rage [2][NSLOT];
  int ehit [2];
  int emiss [2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic touch(input int k, input int s);
    int a = rage[k][s];
    for (int j = 0; j < NSLOT; j++) begin
      if (j == s) rage[k][j] = 0;
      else if (rage[k][j] < a) rage[k][j]++;
    end
  endtask

  // predicts memory writes/reads of one access and updates the model
  task automatic model(input int k, input bit wr, input int blk, output int ew, output int er, output bit h);
    bit wb = (k == 0);
    bit wa = (k == 0);
    int s = -1;
    ew = 0; er = 0;
    for (int j = 0; j < NSLOT; j++) if (rv[k][j] && rtag[k][j] == blk) s = j;
    h = (s >= 0);
    if (h) begin
      ehit[k] = (ehit[k] < CMAX) ? ehit[k] + 1 : CMAX;
      touch(k, s);
      if (wr) begin
        if (wb) rd[k][s] = 1;
        else ew = 1;
      end
    end else begin
      emiss[k] = (emiss[k] < CMAX) ? emiss[k] + 1 : CMAX;
      if (wr && !wa) ew = 1;
      else begin
        int v = -1;
        for (int j = NSLOT - 1; j >= 0; j--) if (!rv[k][j]) v = j;
        if (v < 0) for (int j = 0; j < NSLOT; j++) if (rage[k][j] == NSLOT - 1) v = j;
        if (rv[k][v] && rd[k][v]) ew = 1;
        er = 1;
        rv[k][v] = 1; rtag[k][v] = blk; rd[k][v] = 0;
        touch(k, v);
        if (wr) begin
          if (wb) rd[k][v] = 1;
          else ew = ew + 1;
        end
      end
    end
  endtask

  task automatic drive(input int k, input bit wr, input int addr, input logic [31:0] wd,
                       input bit slow, output logic [31:0] rdata);
    @(negedge clk);
    c_valid[k] = 1'b1; c_write[k] = wr; c_addr[k] = 6'(addr); c_wdata[k] = wd;
    while (!c_ready[k]) @(negedge clk);
    @(negedge clk);
    c_valid[k] = 1'b0;
    while (!r_valid[k]) @(negedge clk);
    if (slow) @(negedge clk);
    rdata = r_data[k];
    r_ready[k] = 1'b1;
    @(negedge clk);
    r_ready[k] = 1'b0;
  endtask

  task automatic access(input bit wr, input int addr, input logic [31:0] wd);
    int blk = addr >> 2;
    int ew [2];
    int er [2];
    bit h [2];
    int w0 [2];
    int r0 [2];
    logic [31:0] rdat [2];
    for (int k = 0; k < 2; k++) begin
      model(k, wr, blk, ew[k], er[k], h[k]);
      w0[k] = wr_cnt[k]; r0[k] = rd_cnt[k];
    end
    fork
      drive(0, wr, addr, wd, addr[0], rdat[0]);
      drive(1, wr, addr, wd, addr[1], rdat[1]);
    join
    if (wr) gm[blk] = wd;
    for (int k = 0; k < 2; k++) begin
      check(hcnt[k] == 8'(ehit[k]), "R9 hit count", 32'(hcnt[k]), 32'(ehit[k]));
      check(mcnt[k] == 8'(emiss[k]), "R4 miss count", 32'(mcnt[k]), 32'(emiss[k]));
      check(wr_cnt[k] - w0[k] == ew[k], wr ? (h[k] ? (k == 0 ? "R6 write hit traffic" : "R5 write hit traffic")
                                              : (k == 0 ? "R7 write miss traffic" : "R8 write miss traffic"))
                                          : "R6 eviction traffic",
            32'(wr_cnt[k] - w0[k]), 32'(ew[k]));
      check(rd_cnt[k] - r0[k] == er[k], h[k] ? "R2 hit reads memory" : "R3 miss fill read",
            32'(rd_cnt[k] - r0[k]), 32'(er[k]));
      if (!wr) check(rdat[k] == gm[blk], h[k] ? "R2 hit data" : "R3 fill data", rdat[k], gm[blk]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lfsr = 16'hACE1;
    c_valid = '0; c_write = '0; r_ready = '0; m_ready = '1;
    for (int k = 0; k < 2; k++) begin
      c_addr[k] = '0; c_wdata[k] = '0;
      ehit[k] = 0; emiss[k] = 0;
      for (int j = 0; j < NSLOT; j++) begin
        rv[k][j] = 0; rd[k][j] = 0; rtag[k][j] = 0; rage[k][j] = j;
      end
    end
    for (int i = 0; i < NBLK; i++) gm[i] = init_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(c_ready[k] == 1'b1, "R1 ready after reset", 32'(c_ready[k]), 1);
      check(m_valid[k] == 1'b0, "R1 no memory request", 32'(m_valid[k]), 0);
      check(hcnt[k] == 0 && mcnt[k] == 0, "R1 counters clear", 32'({hcnt[k], mcnt[k]}), 0);
    end

    // short read sequence: cold misses, LRU victim choice
    access(0, 0, '0); access(0, 2, '0); access(0, 4, '0); access(0, 8, '0);
    access(0, 20, '0); access(0, 16, '0); access(0, 0, '0); access(0, 2, '0);
    check(hcnt[0] == 2 && mcnt[0] == 6, "R4 sequence 2 hits 6 misses",
          32'({hcnt[0], mcnt[0]}), 32'({8'd2, 8'd6}));

    // write on a hit and a miss under both policies
    access(1, 0, 32'h1111_2222);
    access(1, 60, 32'h3333_4444);
    access(0, 60, '0);
    access(0, 0, '0);

    // pseudo-random read/write mix over the whole address space
    for (int n = 0; n < 400; n++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
      access((lfsr & 7) < 3, (lfsr >> 4) & 63, 32'(lfsr) * 32'h9E37_79B1);
    end

    // every byte address in order
    for (int a = 0; a < (1 << ADDR_W); a++) access(0, a, '0);

    // counter saturation
    for (int n = 0; n < 300; n++) access(0, 61, '0);
    for (int k = 0; k < 2; k++)
      check(hcnt[k] == 8'hFF, "R9 hit counter saturates", 32'(hcnt[k]), 32'hFF);

    // memory image: write-through always current, write-back current except dirty blocks
    repeat (3) @(negedge clk);
    for (int b = 0; b < NBLK; b++) begin
      bit dirty_here = 0;
      for (int j = 0; j < NSLOT; j++) if (rv[0][j] && rd[0][j] && rtag[0][j] == b) dirty_here = 1;
      check(mem[1][b] == gm[b], "R5 memory current", mem[1][b], gm[b]);
      if (!dirty_here) check(mem[0][b] == gm[b], "R6 clean block in memory", mem[0][b], gm[b]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule